// File: doc/BRIEF.md
# Guarded Power Enable Register

This block holds the eight-bit power enable byte of a mixed-signal audio front end. It has separate enables for the two playback converters, the two record converters, a transducer driver converter and the two microphone paths. A host interface writes the byte through a single strobe. Reading the byte returns the enables that are actually applied to the analog circuits.

Most bits take effect on the clock edge that follows the write. The two playback-converter bits are guarded. They change only while both serial-data-input enables from the neighbouring format registers are clear and the chip reports that every soft-stop ramp has finished. A guarded write that arrives at the wrong time is parked as a pending value and applied later.

A separate request strobe asks to change the interface mode. The request is refused while any of the four audio converters is on, and a refusal raises a sticky error flag.

Top module: `pwr_gate_reg`

## Requirements
- R1: During reset and on the first cycle after it, every enable is 0. The transducer output is in high impedance, and the pending, error and accept outputs are 0.
- R2: Register bit map: bit 7 is the left playback converter, bit 6 the right playback converter, bit 5 the left record converter, bit 4 the right record converter, bit 3 the transducer converter, bit 1 the left microphone and bit 0 the right microphone. In every bit, 1 means on. A write of bits 5, 4, 3, 1 and 0 shows on `enableOut` one cycle after the strobe. Bit 2 always reads 0, whatever is written to it.
- R3: `transducerHiZ` is 1 exactly when the applied bit 3 is 0.
- R4: The guard holds when `sdiLeftOn` and `sdiRightOn` are both 0 and `softStopDone` is 1. A write that changes bit 7 or bit 6 while the guard holds is applied one cycle after the strobe. The applied bits 7 and 6 never change on an edge where the guard did not hold in the cycle before.
- R5: A write that changes bit 7 or bit 6 while the guard does not hold leaves the applied bits as they are. It stores the written pair as pending and sets `dacPending` on the next cycle. In the first cycle with no write in which the guard holds, the pending pair is applied on the following edge and `dacPending` falls.
- R6: A later write replaces any pending pair. If that later write's bits 7 and 6 equal the applied bits, the pending change is cancelled.
- R7: A `modeReq` pulse while any of bits 7 to 4 is applied sets `modeErr` on the next cycle. The flag stays set until an `errClr` pulse clears it. If a rejection and `errClr` fall in the same cycle, the flag stays set.
- R8: A `modeReq` pulse while bits 7 to 4 are all 0 gives a one-cycle `modeAccept` pulse on the next cycle and leaves `modeErr` unchanged.
- R9: When a write and `modeReq` fall in the same cycle, the request is judged on the enables applied before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the enable byte |
| wrData | input | 8 | Byte written |
| modeReq | input | 1 | Interface-mode change request pulse |
| errClr | input | 1 | Clears the sticky mode error |
| sdiLeftOn | input | 1 | Left serial-data-input enable from its format register |
| sdiRightOn | input | 1 | Right serial-data-input enable from its format register |
| softStopDone | input | 1 | All soft-stop ramps finished |
| enableOut | output | 8 | Applied enable byte (read-back value) |
| transducerHiZ | output | 1 | Transducer output high-impedance control |
| dacPending | output | 1 | A playback-converter change is waiting for the guard |
| modeErr | output | 1 | Sticky rejected-mode-change flag |
| modeAccept | output | 1 | One-cycle pulse for an accepted mode change |

## Verification
Two pairs of events can fall in the same cycle:
- A host write can land in the same cycle as a mode request. The bench drives both in one cycle, for example turning a record converter on from an all-off state. It then expects an accept judged on the old byte, with the new byte visible a cycle later.
- A write can arrive in the very cycle that the guard opens for an older pending pair. The bench expects the new write to win and the pending flag to clear.

Random phases mix all strobes and guard inputs, so both collisions also occur unplanned. Each is judged against a cycle model kept in the bench.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
  localparam int REG_W = 8;
  localparam int DAC_L = 7;
  localparam int DAC_R = 6;
  localparam int ADC_L = 5;
  localparam int ADC_R = 4;
  localparam int XDCR  = 3;
  localparam int MIC_L = 1;
  localparam int MIC_R = 0;
  localparam logic [REG_W-1:0] DIRECT_MASK =
    REG_W'((1 << ADC_L) | (1 << ADC_R) | (1 << XDCR) | (1 << MIC_L) | (1 << MIC_R));

  typedef struct packed {
    logic wrDirect;
    logic wrDac;
    logic pendStore;
    logic pendApply;
    logic errSet;
    logic errClr;
    logic modeOk;
  } strobe_t;
endpackage

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrDacBits,
  input  logic             modeReq,
  input  logic             errClr,
  input  logic             sdiLeftOn,
  input  logic             sdiRightOn,
  input  logic             softStopDone,
  input  logic [REG_W-1:0] applied,
  input  logic             pendFlag,
  input  logic             errFlag,
  input  logic             acceptPulse,
  output strobe_t          strobes
);
  logic       guardOk;
  logic       convOn;
  logic       dacDiff;
  logic [1:0] dacApplied;

  assign dacApplied = {applied[DAC_L], applied[DAC_R]};
  assign guardOk    = !sdiLeftOn && !sdiRightOn && softStopDone;
  assign convOn     = applied[DAC_L] | applied[DAC_R] | applied[ADC_L] | applied[ADC_R];
  assign dacDiff    = wrDacBits != dacApplied;

  always_comb begin
    strobes           = '0;
    strobes.wrDirect  = wrEn;
    strobes.wrDac     = wrEn && (guardOk || !dacDiff);
    strobes.pendStore = wrEn && !guardOk && dacDiff;
    strobes.pendApply = !wrEn && pendFlag && guardOk;
    strobes.errSet    = modeReq && convOn;
    strobes.errClr    = errClr;
    strobes.modeOk    = modeReq && !convOn;
  end

  // R4: applied playback bits only move after a cycle with the guard open
  assert_dac_guard_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacApplied) |-> $past(guardOk));

  // R5: a pending pair drains once the guard opens with no write
  assert_pend_drain_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendFlag && guardOk && !wrEn) |=> !pendFlag);

  // R7: rejection raises the flag, and the flag holds without a clear
  assert_mode_reject_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeReq && convOn) |=> errFlag);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  // R8: accept pulse only follows an allowed request
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeReq && !convOn) |=> acceptPulse);
  assert_no_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(modeReq && !convOn) |=> !acceptPulse);
endmodule

// File: rtl/pwr_gate_dp.sv
module pwr_gate_dp
  import pwr_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] applied,
  output logic             pendFlag,
  output logic             errFlag,
  output logic             acceptPulse,
  output logic             hiZ
);
  logic [REG_W-1:0] directReg;
  logic [1:0]       dacReg;
  logic [1:0]       pendVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      directReg   <= '0;
      dacReg      <= '0;
      pendVal     <= '0;
      pendFlag    <= 1'b0;
      errFlag     <= 1'b0;
      acceptPulse <= 1'b0;
    end else begin
      if (strobes.wrDirect) directReg <= wrData & DIRECT_MASK;
      if (strobes.wrDac) begin
        dacReg   <= {wrData[DAC_L], wrData[DAC_R]};
        pendFlag <= 1'b0;
      end else if (strobes.pendStore) begin
        pendVal  <= {wrData[DAC_L], wrData[DAC_R]};
        pendFlag <= 1'b1;
      end else if (strobes.pendApply) begin
        dacReg   <= pendVal;
        pendFlag <= 1'b0;
      end
      if (strobes.errSet)      errFlag <= 1'b1;
      else if (strobes.errClr) errFlag <= 1'b0;
      acceptPulse <= strobes.modeOk;
    end
  end

  always_comb begin
    applied        = directReg;
    applied[DAC_L] = dacReg[1];
    applied[DAC_R] = dacReg[0];
  end

  assign hiZ = !directReg[XDCR];

  // R2: the spare bit never reads back as set
  always_comb assert_spare_zero_R2: assert (applied[2] == 1'b0);

  // R1: the state leaving reset is all clear
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (applied == '0 && !pendFlag && !errFlag && !acceptPulse));
endmodule

// File: rtl/pwr_gate_reg.sv
module pwr_gate_reg
  import pwr_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             modeReq,
  input  logic             errClr,
  input  logic             sdiLeftOn,
  input  logic             sdiRightOn,
  input  logic             softStopDone,
  output logic [REG_W-1:0] enableOut,
  output logic             transducerHiZ,
  output logic             dacPending,
  output logic             modeErr,
  output logic             modeAccept
);
  strobe_t strobes;

  pwr_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .wrDacBits({wrData[DAC_L], wrData[DAC_R]}),
    .modeReq(modeReq), .errClr(errClr),
    .sdiLeftOn(sdiLeftOn), .sdiRightOn(sdiRightOn), .softStopDone(softStopDone),
    .applied(enableOut), .pendFlag(dacPending), .errFlag(modeErr),
    .acceptPulse(modeAccept), .strobes(strobes)
  );

  pwr_gate_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .applied(enableOut), .pendFlag(dacPending), .errFlag(modeErr),
    .acceptPulse(modeAccept), .hiZ(transducerHiZ)
  );
endmodule

// File: tb/test_pwr_gate_reg.sv
module test_pwr_gate_reg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       modeReq = 1'b0;
  logic       errClr = 1'b0;
  logic       sdiLeftOn = 1'b0;
  logic       sdiRightOn = 1'b0;
  logic       softStopDone = 1'b1;
  logic [7:0] enableOut;
  logic       transducerHiZ, dacPending, modeErr, modeAccept;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] mLow;
  logic [1:0] mDac, mPendV;
  logic       mPend, mErr, mAcc;

  always #4 clk = ~clk;

  pwr_gate_reg i_pwr_gate_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .modeReq(modeReq),
    .errClr(errClr), .sdiLeftOn(sdiLeftOn), .sdiRightOn(sdiRightOn),
    .softStopDone(softStopDone), .enableOut(enableOut), .transducerHiZ(transducerHiZ),
    .dacPending(dacPending), .modeErr(modeErr), .modeAccept(modeAccept)
  );

  function automatic logic [7:0] expByte();
    return {mDac, mLow[5:0]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mLow = '0; mDac = '0; mPendV = '0; mPend = 0; mErr = 0; mAcc = 0;
  endtask

  task automatic modelStep();
    logic guard, conv;
    guard = !sdiLeftOn && !sdiRightOn && softStopDone;
    conv  = (mDac != 2'b00) || mLow[5] || mLow[4];   // R9: judged on old state
    mAcc  = modeReq && !conv;
    if (modeReq && conv) mErr = 1'b1;
    else if (errClr)     mErr = 1'b0;
    if (wrEn) begin
      mLow = wrData & 8'h3B;
      if (guard || wrData[7:6] == mDac) begin mDac = wrData[7:6]; mPend = 0; end
      else begin mPendV = wrData[7:6]; mPend = 1; end
    end else if (mPend && guard) begin
      mDac = mPendV; mPend = 0;
    end
  endtask

  // step one clock: inputs set before the edge, outputs sampled 2 ns after it
  task automatic step();
    @(posedge clk);
    modelStep();
    #2;
    wrEn = 0; modeReq = 0; errClr = 0;
  endtask

  task automatic chkAll();
    chk("R2/R4 enables", enableOut, expByte());
    chk("R3 hiZ", {7'd0, transducerHiZ}, {7'd0, !mLow[3]});
    chk("R5 pending", {7'd0, dacPending}, {7'd0, mPend});
    chk("R7 modeErr", {7'd0, modeErr}, {7'd0, mErr});
    chk("R8 accept", {7'd0, modeAccept}, {7'd0, mAcc});
  endtask

  task automatic doWrite(input logic [7:0] d);
    wrEn = 1; wrData = d; step();
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    modelReset();
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 enables", enableOut, 8'h00);
    chk("R1 hiZ", {7'd0, transducerHiZ}, 8'h01);
    chk("R1 flags", {5'd0, dacPending, modeErr, modeAccept}, 8'h00);
    rstN = 1;
    step(); chkAll();

    // R2: spare bit reads 0, all guarded bits applied with guard open (R4)
    doWrite(8'hFF);
    chk("R2 bit map", enableOut, 8'hFB);
    chk("R3 hiZ low", {7'd0, transducerHiZ}, 8'h00);
    chkAll();
    // R7: mode request with converters on
    modeReq = 1; step();
    chk("R7 reject", {7'd0, modeErr}, 8'h01);
    step(); chk("R7 sticky", {7'd0, modeErr}, 8'h01);
    // R7: clear and reject in same cycle keeps flag set
    modeReq = 1; errClr = 1; step();
    chk("R7 set wins", {7'd0, modeErr}, 8'h01);
    errClr = 1; step();
    chk("R7 clear", {7'd0, modeErr}, 8'h00);

    // R5: blocked write held pending
    sdiLeftOn = 1;
    doWrite(8'h3B);
    chk("R5 held", enableOut, 8'hFB);
    chk("R5 flag", {7'd0, dacPending}, 8'h01);
    // R6: later write replaces pending
    doWrite(8'h7B);
    chk("R6 replace", {7'd0, dacPending}, 8'h01);
    sdiLeftOn = 0; softStopDone = 0; step();
    chk("R4 softstop block", enableOut, 8'hFB);
    softStopDone = 1; step();
    chk("R5 applied", enableOut, 8'h7B);
    chk("R5 flag clear", {7'd0, dacPending}, 8'h00);
    // R6: write equal to applied cancels pending
    sdiRightOn = 1; doWrite(8'h3B);
    chk("R6 pend set", {7'd0, dacPending}, 8'h01);
    doWrite(8'h73);
    chk("R6 cancel", {7'd0, dacPending}, 8'h00);
    chk("R6 cancel bits", enableOut, 8'h73);
    sdiRightOn = 0; step();
    chk("R6 no late apply", enableOut, 8'h73);

    // R9: write and mode request together, judged on old byte
    doWrite(8'h0B);
    modeReq = 1; step();
    chk("R8 accept", {7'd0, modeAccept}, 8'h01);
    step(); chk("R8 one cycle", {7'd0, modeAccept}, 8'h00);
    wrEn = 1; wrData = 8'h20; modeReq = 1; step();
    chk("R9 accept on old", {7'd0, modeAccept}, 8'h01);
    chk("R9 err clear", {7'd0, modeErr}, 8'h00);
    chk("R9 new byte", enableOut, 8'h20);
    chk("R3 hiZ high", {7'd0, transducerHiZ}, 8'h01);
    chkAll();

    // random phase, every output compared to the model each cycle
    for (int i = 0; i < 2000; i++) begin
      wrEn = ($urandom % 3) == 0;
      wrData = 8'($urandom);
      modeReq = ($urandom % 5) == 0;
      errClr = ($urandom % 6) == 0;
      sdiLeftOn = ($urandom % 3) == 0;
      sdiRightOn = ($urandom % 4) == 0;
      softStopDone = ($urandom % 4) != 0;
      step();
      chkAll();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule